// File: doc/BRIEF.md
# Serial configuration ROM read responder

This block stands in for a small three-wire serial EEPROM that holds a network controller's configuration words: a format version, a chip count, the station MAC address and an offset to per-chip information. Software drives it by bit-banging. Each accepted write carries a chip-select bit, a serial-clock bit and a data-in bit. The block answers on a registered data-out bit that software reads back after each clocked write.

Only the read command is served. A frame is a three-bit opcode, a word address and a sixteen-bit data field, each sent most significant bit first. While the address arrives, the block echoes ones and then a single zero on the last address bit, so a host can find the address width by watching for the zero. Zeros sent before the first one bit are skipped. Once the last data bit has gone out, the frame state clears by itself, so back-to-back reads work without lowering chip-select. Other opcodes are decoded and then ignored: data-out stays low for the rest of such a frame. The image is built at elaboration from a MAC-address parameter.

Top module: `srom_responder`

## Requirements
- R1: After a synchronous reset, dout is 0 and the first clocked one bit begins a new opcode.
- R2: A write only steps the frame when wr_en and wr_sclk are both 1. A cycle with wr_en low, or a write with wr_sclk 0 and no chip-select rise, leaves dout and the frame position unchanged.
- R3: A write with wr_cs 1, where the previous write had wr_cs 0 (0 after reset), clears the bit count, opcode, address and started flag before that write's data bit is used.
- R4: Clocked zero bits that arrive before the first clocked one bit of a frame are skipped and do not count toward the frame.
- R5: The opcode is three bits, most significant first, and begins with its first one bit. The value 3'b110 means read. dout holds its previous value during the three opcode bits.
- R6: In a read, the six address bits are shifted in most significant first. dout is 1 after each of the first five address bits and 0 after the sixth.
- R7: In a read, the next sixteen clocked bits drive dout with the addressed word, bit 15 first. The word's low byte is image byte 2*A and its high byte is image byte 2*A+1.
- R8: After 25 counted bits (3+6+16), the frame state clears by itself, so a following read needs no chip-select toggle.
- R9: For any opcode other than 3'b110, dout is 0 after every address and data bit of that frame, and the frame still ends after 25 counted bits.
- R10: The image bytes are: byte 18 = 1 (format version), byte 19 = 1 (chip count), bytes 20..25 = the MAC address with its most significant byte at 20, byte 26 = 0, bytes 27..28 = 30 stored little-endian (info offset), and every other byte 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Strobe: one control-word write in this cycle |
| wr_cs | input | 1 | Chip-select bit of the written control word |
| wr_sclk | input | 1 | Serial-clock bit of the written control word |
| wr_din | input | 1 | Serial data-in bit of the written control word |
| dout | output | 1 | Registered serial data-out bit |

## Verification
The bench targets the address echo. A design that drops the trailing zero, or places it one bit early, would report the wrong address width to the host. It varies the number of leading zeros; a design that counts them would shift the opcode and return the wrong word. It runs many reads back to back with chip-select held high, and raises chip-select again partway through a frame; a design without the self-clear would never answer the second read, and one that ignored the chip-select rise would stay out of step. Non-read opcodes are mixed in and must keep dout low, and the byte order inside each word is checked against the image, where swapped bytes would scramble the MAC address.

// File: rtl/srom_pkg.sv
package srom_pkg;

    localparam int OPC_BITS  = 3;
    localparam int WORD_BITS = 16;
    localparam logic [OPC_BITS-1:0] OPC_READ = 3'b110;

    // image layout, fixed because the host decodes it
    localparam int OFS_VERSION = 18;
    localparam int OFS_CHIPS   = 19;
    localparam int OFS_MAC     = 20;
    localparam int OFS_LEAF    = 27;
    localparam int LEAF_AT     = 30;

    typedef enum logic [1:0] {
        PH_OPCODE,
        PH_ADDRESS,
        PH_DATA
    } phase_e;

    function automatic logic [7:0] image_byte(input int idx, input logic [47:0] mac);
        logic [7:0] b;
        b = 8'h00;
        if (idx == OFS_VERSION)                        b = 8'd1;
        else if (idx == OFS_CHIPS)                     b = 8'd1;
        else if (idx >= OFS_MAC && idx < OFS_MAC + 6)  b = mac[8*(OFS_MAC + 5 - idx) +: 8];
        else if (idx == OFS_LEAF)                      b = 8'(LEAF_AT);
        else if (idx == OFS_LEAF + 1)                  b = 8'(LEAF_AT >> 8);
        return b;
    endfunction

endpackage

// File: rtl/srom_image.sv
module srom_image #(
    parameter int          ROM_BYTES = 128,
    parameter logic [47:0] MAC_ADDR  = 48'h02_00_5E_10_20_30,
    localparam int         ADDR_W    = $clog2(ROM_BYTES / 2)
) (
    input  logic [ADDR_W-1:0] word_addr,
    output logic [15:0]       word
);
    import srom_pkg::*;

    logic [7:0] bytes_q [ROM_BYTES];

    for (genvar g = 0; g < ROM_BYTES; g++) begin : g_byte
        assign bytes_q[g] = image_byte(g, MAC_ADDR);
    end

    // high byte from the odd location, low byte from the even one
    assign word = {bytes_q[{word_addr, 1'b1}], bytes_q[{word_addr, 1'b0}]};

endmodule

// File: rtl/srom_serial.sv
module srom_serial #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_cs,
    input  logic              wr_sclk,
    input  logic              wr_din,
    input  logic [15:0]       word_i,
    output logic [ADDR_W-1:0] word_addr,
    output logic              dout
);
    import srom_pkg::*;

    localparam int FRAME_BITS = OPC_BITS + ADDR_W + WORD_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] OPC_END   = CNT_W'(OPC_BITS);
    localparam logic [CNT_W-1:0] ADDR_END  = CNT_W'(OPC_BITS + ADDR_W);
    localparam logic [CNT_W-1:0] ECHO_ZERO = CNT_W'(OPC_BITS + ADDR_W - 1);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic [CNT_W-1:0]    cnt;
        logic [OPC_BITS-1:0] opc;
        logic [ADDR_W-1:0]   addr;
        logic                started;
    } frame_t;

    frame_t st, base, nxt;
    logic   cs_q, dout_q, dout_n;
    logic   cs_rise, clk_bit;
    phase_e phase;

    assign cs_rise = wr_en && wr_cs && !cs_q;
    assign clk_bit = wr_en && wr_sclk;

    always_comb begin
        base = cs_rise ? '0 : st;
        if (base.cnt < OPC_END)       phase = PH_OPCODE;
        else if (base.cnt < ADDR_END) phase = PH_ADDRESS;
        else                          phase = PH_DATA;
    end

    always_comb begin
        nxt    = base;
        dout_n = dout_q;
        if (clk_bit && (wr_din || base.started)) begin
            case (phase)
                PH_OPCODE: begin
                    nxt.started = 1'b1;
                    nxt.opc     = {base.opc[OPC_BITS-2:0], wr_din};
                end
                PH_ADDRESS: begin
                    if (base.opc == OPC_READ) begin
                        dout_n   = (base.cnt != ECHO_ZERO);
                        nxt.addr = ADDR_W'({base.addr, wr_din});
                    end else begin
                        dout_n = 1'b0;
                    end
                end
                default: begin
                    if (base.opc == OPC_READ)
                        dout_n = word_i[4'(LAST_BIT - base.cnt)];
                    else
                        dout_n = 1'b0;
                end
            endcase
            nxt.cnt = base.cnt + 1'b1;
            if (base.cnt == LAST_BIT)
                nxt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '0;
            cs_q   <= 1'b0;
            dout_q <= 1'b0;
        end else begin
            st     <= nxt;
            dout_q <= dout_n;
            if (wr_en)
                cs_q <= wr_cs;
        end
    end

    assign word_addr = st.addr;
    assign dout      = dout_q;

    // R2: no clock bit and no select rise means nothing moves
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!clk_bit && !cs_rise) |=> ($stable(dout_q) && $stable(st)));

    // R3: a select rise without a clock leaves an empty frame
    assert_cs_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && !wr_sclk) |=> (st.cnt == '0 && !st.started));

    // R5: opcode bits do not disturb data-out
    assert_opcode_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (clk_bit && !cs_rise && st.cnt < OPC_END && (wr_din || st.started))
        |=> $stable(dout_q));

    // R6: the final address bit of a read echoes a zero
    assert_echo_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (clk_bit && !cs_rise && st.opc == OPC_READ && st.cnt == ECHO_ZERO) |=> !dout_q);

    // R8: the last counted bit empties the frame
    assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (clk_bit && !cs_rise && st.cnt == LAST_BIT) |=> (st.cnt == '0 && !st.started));

    // R9: past the opcode, a non-read frame keeps data-out low
    assert_bad_op_low_R9: assert property (@(posedge clk) disable iff (rst)
        (clk_bit && !cs_rise && st.cnt >= OPC_END && st.opc != OPC_READ) |=> !dout_q);

endmodule

// File: rtl/srom_responder.sv
module srom_responder #(
    parameter int          ROM_BYTES = 128,
    parameter logic [47:0] MAC_ADDR  = 48'h02_00_5E_10_20_30
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_cs,
    input  logic wr_sclk,
    input  logic wr_din,
    output logic dout
);
    localparam int ADDR_W = $clog2(ROM_BYTES / 2);

    logic [ADDR_W-1:0] word_addr;
    logic [15:0]       word;

    srom_image #(
        .ROM_BYTES (ROM_BYTES),
        .MAC_ADDR  (MAC_ADDR)
    ) u_image (
        .word_addr (word_addr),
        .word      (word)
    );

    srom_serial #(
        .ADDR_W (ADDR_W)
    ) u_serial (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_cs     (wr_cs),
        .wr_sclk   (wr_sclk),
        .wr_din    (wr_din),
        .word_i    (word),
        .word_addr (word_addr),
        .dout      (dout)
    );

endmodule

// File: tb/srom_responder_tb.sv
module srom_responder_tb;
    localparam logic [47:0] MAC = 48'h02_00_5E_10_20_30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, wr_cs = 1'b0, wr_sclk = 1'b0, wr_din = 1'b0;
    logic dout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int m_cnt, m_opc, m_addr;
    bit m_started, m_cs, m_dout;

    always #5 clk = ~clk;

    srom_responder #(.ROM_BYTES(128), .MAC_ADDR(MAC)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cs(wr_cs),
        .wr_sclk(wr_sclk), .wr_din(wr_din), .dout(dout)
    );

    function automatic int exp_byte(int idx);
        if (idx == 18 || idx == 19) return 1;
        if (idx >= 20 && idx <= 25) return int'(MAC[8*(25 - idx) +: 8]);
        if (idx == 27) return 30;
        return 0;
    endfunction

    function automatic int exp_word(int a);
        return (exp_byte(2*a + 1) << 8) | exp_byte(2*a);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        m_cnt = 0; m_opc = 0; m_addr = 0; m_started = 0;
    endtask

    function automatic string phase_tag();
        if (m_cnt < 3) return "R5";
        if (m_opc != 6) return "R9";
        if (m_cnt < 9) return "R6";
        return "R7";
    endfunction

    task automatic model_write(bit en, bit cs, bit sclk, bit din);
        if (!en) return;
        if (cs && !m_cs) model_clear();
        m_cs = cs;
        if (sclk && (din || m_started)) begin
            if (m_cnt < 3) begin
                m_started = 1;
                m_opc = ((m_opc << 1) | int'(din)) & 7;
            end else if (m_opc == 6) begin
                if (m_cnt < 9) begin
                    m_dout = (m_cnt < 8);
                    m_addr = ((m_addr << 1) | int'(din)) & 63;
                end else begin
                    m_dout = bit'((exp_word(m_addr) >> (15 - (m_cnt - 9))) & 1);
                end
            end else begin
                m_dout = 0;
            end
            m_cnt++;
            if (m_cnt == 25) model_clear();
        end
    endtask

    // one cycle of stimulus, then compare dout with the model
    task automatic step(bit en, bit cs, bit sclk, bit din);
        string tag;
        bool_tag: begin
            if (en && sclk) tag = phase_tag();
            else tag = "R2";
        end
        wr_en = en; wr_cs = cs; wr_sclk = sclk; wr_din = din;
        @(posedge clk);
        #1;
        model_write(en, cs, sclk, din);
        wr_en = 1'b0;
        @(negedge clk);
        check(dout === m_dout, tag, int'(dout), int'(m_dout));
    endtask

    // sometimes insert non-clocking cycles
    task automatic maybe_idle(bit noisy);
        if (noisy && ($urandom % 4 == 0)) begin
            if ($urandom % 2 == 0) step(1'b0, 1'b1, 1'b1, bit'($urandom % 2));
            else                   step(1'b1, 1'b1, 1'b0, bit'($urandom % 2));
        end
    endtask

    task automatic frame(int zeros, int opc, int a, bit noisy, output int got);
        got = 0;
        for (int i = 0; i < zeros; i++) begin
            step(1'b1, 1'b1, 1'b1, 1'b0);
            maybe_idle(noisy);
        end
        for (int i = 2; i >= 0; i--) begin
            step(1'b1, 1'b1, 1'b1, bit'((opc >> i) & 1));
            maybe_idle(noisy);
        end
        for (int i = 5; i >= 0; i--) begin
            step(1'b1, 1'b1, 1'b1, bit'((a >> i) & 1));
            maybe_idle(noisy);
        end
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 1'b1, 1'b1, bit'($urandom % 2));
            got = (got << 1) | int'(dout);
            maybe_idle(noisy);
        end
    endtask

    initial begin
        int got;
        int echo_ones;
        bit last_echo;
        void'($urandom(32'd20240611));
        model_clear();
        m_cs = 0; m_dout = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(dout === 1'b0, "R1 reset dout", int'(dout), 0);

        // R1/R4: leading zeros then a first read
        frame(3, 6, 10, 1'b0, got);
        check(got == exp_word(10), "R4 read after leading zeros", got, exp_word(10));

        // R6: watch the address echo explicitly
        echo_ones = 0;
        for (int i = 2; i >= 0; i--) step(1'b1, 1'b1, 1'b1, bit'((6 >> i) & 1));
        for (int i = 5; i >= 0; i--) begin
            step(1'b1, 1'b1, 1'b1, bit'((5 >> i) & 1));
            if (i > 0 && dout === 1'b1) echo_ones++;
            last_echo = dout;
        end
        check(echo_ones == 5, "R6 echo ones", echo_ones, 5);
        check(last_echo == 1'b0, "R6 echo trailing zero", int'(last_echo), 0);
        got = 0;
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 1'b1, 1'b1, 1'b0);
            got = (got << 1) | int'(dout);
        end
        check(got == exp_word(5), "R7 word 5", got, exp_word(5));

        // R8/R7: every word back to back, select held high
        for (int a = 0; a < 64; a++) begin
            frame(0, 6, a, 1'b0, got);
            check(got == exp_word(a), "R8 sequential read", got, exp_word(a));
        end

        // R10: fixed image content
        frame(0, 6, 9, 1'b0, got);
        check(got == 16'h0101, "R10 version and chip count", got, 16'h0101);
        frame(0, 6, 10, 1'b0, got);
        check(got == {8'h00, 8'h02}, "R10 first MAC bytes", got, 16'h0002);
        frame(0, 6, 13, 1'b0, got);
        check(got == 16'h1E00, "R10 leaf offset low byte", got, 16'h1E00);
        frame(0, 6, 14, 1'b0, got);
        check(got == 16'h0000, "R10 leaf offset high byte", got, 0);

        // R9: non-read opcodes keep dout low, then a read still works
        frame(0, 7, 12, 1'b0, got);
        check(got == 0, "R9 opcode 111", got, 0);
        frame(2, 5, 33, 1'b0, got);
        check(got == 0, "R9 opcode 101", got, 0);
        frame(0, 4, 63, 1'b0, got);
        check(got == 0, "R9 opcode 100", got, 0);
        frame(0, 6, 11, 1'b0, got);
        check(got == exp_word(11), "R9 read after bad opcodes", got, exp_word(11));

        // R2: non-clocking writes and idle cycles mid-frame
        frame(1, 6, 12, 1'b1, got);
        check(got == exp_word(12), "R2 read with idle writes", got, exp_word(12));

        // R3: abandon a frame, re-select, start fresh
        for (int i = 0; i < 7; i++) step(1'b1, 1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        frame(0, 6, 11, 1'b0, got);
        check(got == exp_word(11), "R3 read after reselect", got, exp_word(11));

        // random mix
        for (int n = 0; n < 300; n++) begin
            int opc, a, z;
            z = int'($urandom % 4);
            opc = 4 | int'($urandom % 4);
            if ($urandom % 3 != 0) opc = 6;
            a = int'($urandom % 64);
            if ($urandom % 10 == 0) begin
                for (int i = 0; i < int'($urandom % 12); i++) step(1'b1, 1'b1, 1'b1, bit'($urandom % 2));
                step(1'b1, 1'b0, bit'($urandom % 2), 1'b0);
                model_clear();
                m_cs = 0;
            end
            frame(z, opc, a, 1'b1, got);
            if (opc == 6) check(got == exp_word(a), "R7 random read", got, exp_word(a));
            else          check(got == 0, "R9 random bad opcode", got, 0);
        end

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule